// File: doc/BRIEF.md
# System Management Interrupt Generator

This block drives a single system management interrupt line. Several internal event request lines and one external interrupt input feed it. Each source owns a sticky bit in a status register. When a source fires while the line is idle, the line becomes active. A control register selects how long the line stays active. In level mode it stays active until the host has cleared every status bit. In level-with-timeout mode it stays active until the status is cleared or a programmed interval runs out, whichever happens first. In pulse mode it stays active for exactly one interval. The active level of the line is programmable.

The host reaches three registers through a simple write strobe and a separate read address with combinational read data. The interval is an 8-bit register counted in ticks of a prescaled timebase. The `TICK_DIV` parameter sets how many clock cycles make one tick.

Top module: `smi_gen`

## Requirements
- R1: After reset the control, interval and status registers read 0, and the interrupt line sits at its idle level, which is high because the reset polarity is active-low.
- R2: Control bit 2 selects polarity: 1 makes the line active-high, 0 makes it active-low.
- R3: An `evt_req[i]` pulse sets status bit i. A rising edge of `ext_irq` sets status bit `NUM_EVT`. If any bit is set while the line is inactive, the line becomes active in the cycle after the request is sampled.
- R4: Pulse mode is control bits [1:0] = 00. The line stays active for exactly N*TICK_DIV cycles, where N is the interval register, and then returns to idle whatever the status holds.
- R5: In pulse mode, an event that arrives while the line is active sets its status bit but does not lengthen the pulse.
- R6: Level mode is control bit 0 = 1, bit 1 = 0. The line stays active with no time limit while any status bit is set. It returns to idle one cycle after the status becomes all zero.
- R7: Level-with-timeout mode is control bits [1:0] = 10. The line returns to idle after N*TICK_DIV cycles, or one cycle after the status becomes all zero if that comes first. A timeout leaves the status bits set.
- R8: Control bits [1:0] = 11 behaves as level mode.
- R9: Status bits are sticky. Writing 1 to a bit clears it. A request and a clear of the same bit in the same cycle leave the bit set.
- R10: `ext_irq` is edge sensitive. Holding it high sets its status bit once, triggers once, and does not set the bit again after it is cleared.
- R11: An interval of 0 acts as an interval of 1 tick.
- R12: Address 0 is control, 1 is interval, 2 is status (bit i at position i), and 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_req | input | NUM_EVT | Internal event request pulses, one per source |
| ext_irq | input | 1 | External interrupt input, acts on its rising edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DW | Read data for `rd_addr` |
| smi_o | output | 1 | Interrupt line at its programmed polarity |

## Verification
The bench sends a second event into an active pulse. A design that reloads the counter would stretch the pulse past N*TICK_DIV cycles. In level mode it clears the status bits one at a time. A design that releases on a partial clear, or that lets a timeout end level mode, would drop the line too early. In timeout mode it tests both ways out: after expiry the status must still be set, and a clear before expiry must release the line at once. It also holds `ext_irq` high across a clear, asks for a set and a clear on the same bit in the same cycle, and programs an interval of zero. These catch a level-sensitive external input, a clear that wins over a set, and a counter that wraps to 256 ticks.

// File: rtl/smi_pkg.sv
package smi_pkg;

    typedef enum logic [1:0] {
        MODE_PULSE    = 2'd0,
        MODE_LEVEL_TO = 2'd1,
        MODE_LEVEL    = 2'd2
    } smi_mode_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_INTV = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int CTRL_HOLD_BIT = 0;
    localparam int CTRL_TMO_BIT  = 1;
    localparam int CTRL_POL_BIT  = 2;

    function automatic smi_mode_e decode_mode(input logic hold, input logic tmo);
        if (hold)
            return MODE_LEVEL;
        else if (tmo)
            return MODE_LEVEL_TO;
        else
            return MODE_PULSE;
    endfunction

endpackage

// File: rtl/smi_srcs.sv
module smi_srcs #(
    parameter int NUM_EVT = 4,
    localparam int NS     = NUM_EVT + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_req,
    input  logic               ext_irq,
    output logic [NS-1:0]      set_vec
);

    typedef struct packed {
        logic ext_prev;
    } src_t;

    src_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.ext_prev = ext_irq;
        for (int i = 0; i < NUM_EVT; i++) begin
            set_vec[i] = evt_req[i];
        end
        set_vec[NUM_EVT] = ext_irq & ~st_q.ext_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/smi_regs.sv
module smi_regs #(
    parameter int NS = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    input  logic [NS-1:0] set_vec,
    output logic          ctrl_hold,
    output logic          ctrl_tmo,
    output logic          ctrl_pol,
    output logic [DW-1:0] intv,
    output logic [NS-1:0] stat,
    output logic [DW-1:0] rd_data
);
    import smi_pkg::*;

    typedef struct packed {
        logic          hold;
        logic          tmo;
        logic          pol;
        logic [DW-1:0] intv;
        logic [NS-1:0] stat;
    } reg_t;

    reg_t r_d, r_q;
    logic [NS-1:0] clr_vec;
    logic [NS-1:0] stat_nxt;

    // one status cell per source: a set in the same cycle beats a clear
    for (genvar g = 0; g < NS; g++) begin : g_stat
        assign stat_nxt[g] = set_vec[g] | (r_q.stat[g] & ~clr_vec[g]);
    end

    always_comb begin
        r_d     = r_q;
        clr_vec = '0;
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL: begin
                    r_d.hold = wr_data[CTRL_HOLD_BIT];
                    r_d.tmo  = wr_data[CTRL_TMO_BIT];
                    r_d.pol  = wr_data[CTRL_POL_BIT];
                end
                ADDR_INTV: r_d.intv = wr_data;
                ADDR_STAT: clr_vec  = wr_data[NS-1:0];
                default: ;
            endcase
        end
        r_d.stat = stat_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL: begin
                rd_data[CTRL_HOLD_BIT] = r_q.hold;
                rd_data[CTRL_TMO_BIT]  = r_q.tmo;
                rd_data[CTRL_POL_BIT]  = r_q.pol;
            end
            ADDR_INTV: rd_data         = r_q.intv;
            ADDR_STAT: rd_data[NS-1:0] = r_q.stat;
            default: ;
        endcase
    end

    assign ctrl_hold = r_q.hold;
    assign ctrl_tmo  = r_q.tmo;
    assign ctrl_pol  = r_q.pol;
    assign intv      = r_q.intv;
    assign stat      = r_q.stat;

endmodule

// File: rtl/smi_timer.sv
module smi_timer #(
    parameter int TICK_DIV = 4,
    parameter int DW       = 8,
    localparam int PW      = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    input  logic [DW-1:0] load_val,
    output logic          expire,
    output logic [DW-1:0] cnt_o
);

    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] presc;
        logic [DW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic tick;
    logic last_tick;

    always_comb begin
        t_d       = t_q;
        tick      = run && (t_q.presc == LAST);
        last_tick = (t_q.cnt <= DW'(1));
        expire    = tick && last_tick;
        if (start) begin
            t_d.presc = '0;
            t_d.cnt   = load_val;
        end else if (run) begin
            if (tick) begin
                t_d.presc = '0;
                t_d.cnt   = last_tick ? '0 : t_q.cnt - DW'(1);
            end else begin
                t_d.presc = t_q.presc + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign cnt_o = t_q.cnt;

endmodule

// File: rtl/smi_gen.sv
module smi_gen #(
    parameter int NUM_EVT  = 4,
    parameter int TICK_DIV = 4,
    parameter int DW       = 8,
    localparam int NS      = NUM_EVT + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_req,
    input  logic               ext_irq,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [1:0]         rd_addr,
    output logic [DW-1:0]      rd_data,
    output logic               smi_o
);
    import smi_pkg::*;

    logic [NS-1:0] set_vec;
    logic [NS-1:0] stat;
    logic [DW-1:0] intv;
    logic [DW-1:0] tmr_cnt;
    logic          ctrl_hold, ctrl_tmo, ctrl_pol;
    logic          start, expire;
    smi_mode_e     mode;

    typedef struct packed {
        logic active;
    } ctl_t;

    ctl_t c_d, c_q;

    smi_srcs #(.NUM_EVT(NUM_EVT)) u_srcs (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_req (evt_req),
        .ext_irq (ext_irq),
        .set_vec (set_vec)
    );

    smi_regs #(.NS(NS), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .set_vec   (set_vec),
        .ctrl_hold (ctrl_hold),
        .ctrl_tmo  (ctrl_tmo),
        .ctrl_pol  (ctrl_pol),
        .intv      (intv),
        .stat      (stat),
        .rd_data   (rd_data)
    );

    smi_timer #(.TICK_DIV(TICK_DIV), .DW(DW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .run      (c_q.active),
        .load_val (intv),
        .expire   (expire),
        .cnt_o    (tmr_cnt)
    );

    always_comb begin
        c_d   = c_q;
        mode  = decode_mode(ctrl_hold, ctrl_tmo);
        start = !c_q.active && (|set_vec);
        if (start) begin
            c_d.active = 1'b1;
        end else if (c_q.active) begin
            unique case (mode)
                MODE_LEVEL: begin
                    if (stat == '0 && set_vec == '0) c_d.active = 1'b0;
                end
                MODE_LEVEL_TO: begin
                    if (expire || (stat == '0 && set_vec == '0)) c_d.active = 1'b0;
                end
                default: begin
                    if (expire) c_d.active = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign smi_o = ctrl_pol ? c_q.active : ~c_q.active;

endmodule

// File: rtl/smi_gen_chk.sv
module smi_gen_chk #(
    parameter int NS = 5,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          active,
    input logic          hold,
    input logic          tmo,
    input logic          expire,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic [NS-1:0] set_vec,
    input logic [NS-1:0] stat,
    input logic [DW-1:0] cnt
);

    // R3
    trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && set_vec != '0) |=> active);

    // R3
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && set_vec == '0) |=> !active);

    // R5
    pulse_norestart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !hold && !tmo && !expire) |=> (cnt <= $past(cnt)));

    // R6
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && hold && stat != '0) |=> active);

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (hold || tmo) && stat == '0 && set_vec == '0) |=> !active);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 2'd2) |=> (($past(stat) & ~stat) == '0));

endmodule

bind smi_gen smi_gen_chk #(.NS(NS), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (c_q.active),
    .hold    (ctrl_hold),
    .tmo     (ctrl_tmo),
    .expire  (expire),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .set_vec (set_vec),
    .stat    (stat),
    .cnt     (tmr_cnt)
);

// File: tb/sim_smi_gen.sv
`timescale 1ns/1ps
module sim_smi_gen;

    localparam int NEV = 4;
    localparam int D   = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NEV-1:0] evt_req = '0;
    logic           ext_irq = 1'b0;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_addr = '0;
    logic [7:0]     wr_data = '0;
    logic [1:0]     rd_addr = 2'd2;
    logic [7:0]     rd_data;
    logic           smi_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    smi_gen #(.NUM_EVT(NEV), .TICK_DIV(D), .DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .ext_irq(ext_irq),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .smi_o(smi_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        bit         is_rd;
        logic [7:0] val;
        string      tag;
    } item_t;

    item_t sb[$];

    task automatic expect_at(int at, bit is_rd, logic [7:0] v, string tag);
        int i;
        item_t it;
        it.at = at; it.is_rd = is_rd; it.val = v; it.tag = tag;
        i = 0;
        while (i < sb.size() && sb[i].at <= at) i++;
        sb.insert(i, it);
    endtask

    function automatic logic [7:0] lvl(bit pol, bit act);
        return {7'b0, pol ? act : ~act};
    endfunction

    // monitor: compares due items at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (it.at < cyc) begin
                errors++;
                $display("FAIL %s: check for cycle %0d missed at %0d, actual n/a expected %0h",
                         it.tag, it.at, cyc, it.val);
            end else if (it.is_rd) begin
                if (rd_data !== it.val) begin
                    errors++;
                    $display("FAIL %s: cycle %0d rd_data actual %0h expected %0h",
                             it.tag, cyc, rd_data, it.val);
                end
            end else if (smi_o !== it.val[0]) begin
                errors++;
                $display("FAIL %s: cycle %0d smi_o actual %0b expected %0b",
                         it.tag, cyc, smi_o, it.val[0]);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic tick_to(int target);
        while (cyc < target) tick(1);
    endtask

    task automatic reg_wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_evt(int idx);
        evt_req[idx] = 1'b1;
        tick(1);
        evt_req = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual cycle %0d expected finish earlier", cyc);
        finish_run();
    end

    initial begin
        int e, w;
        tick(3);
        rst_n = 1'b1;
        // R1 R12: reset values at each address
        rd_addr = 2'd0; expect_at(cyc, 1, 8'h00, "R1 ctrl");
        expect_at(cyc, 0, 8'h01, "R1 idle high");
        tick(1); rd_addr = 2'd1; expect_at(cyc, 1, 8'h00, "R1 intv");
        tick(1); rd_addr = 2'd2; expect_at(cyc, 1, 8'h00, "R1 stat");
        tick(1);

        // R4 R2 R5: pulse mode, active-low, second event ignored by timer
        reg_wr(2'd1, 8'd3);
        expect_at(cyc, 0, lvl(0, 0), "R2 idle");
        pulse_evt(0); e = cyc;
        expect_at(e,          0, lvl(0, 1), "R3 R2 assert low");
        expect_at(e + 3*D-1,  0, lvl(0, 1), "R4 last active");
        expect_at(e + 3*D,    0, lvl(0, 0), "R4 R5 end of pulse");
        expect_at(e + 3*D,    1, 8'h03,     "R9 R5 status");
        tick(2);
        pulse_evt(1);
        tick_to(e + 3*D);
        reg_wr(2'd2, 8'hFF);
        expect_at(cyc, 1, 8'h00, "R9 clear");

        // R6: level mode, active-high
        reg_wr(2'd0, 8'h05);
        pulse_evt(2); e = cyc;
        expect_at(e, 0, lvl(1, 1), "R6 assert");
        pulse_evt(0);
        tick(30);
        expect_at(cyc, 0, lvl(1, 1), "R6 held past interval");
        reg_wr(2'd2, 8'h04); w = cyc;
        expect_at(w, 1, 8'h01, "R9 partial clear");
        tick(1);
        expect_at(cyc, 0, lvl(1, 1), "R6 partial keeps line");
        reg_wr(2'd2, 8'h01); w = cyc;
        expect_at(w, 0, lvl(1, 1), "R6 still active on clear edge");
        tick(1);
        expect_at(cyc, 0, lvl(1, 0), "R6 release");
        tick(1);

        // R7: level with timeout
        reg_wr(2'd1, 8'd2);
        reg_wr(2'd0, 8'h06);
        pulse_evt(3); e = cyc;
        expect_at(e,         0, lvl(1, 1), "R7 assert");
        expect_at(e + 2*D-1, 0, lvl(1, 1), "R7 before timeout");
        expect_at(e + 2*D,   0, lvl(1, 0), "R7 timeout");
        expect_at(e + 2*D,   1, 8'h08,     "R7 status kept");
        tick_to(e + 2*D);
        pulse_evt(0); e = cyc;
        expect_at(e, 0, lvl(1, 1), "R7 retrigger");
        tick(2);
        reg_wr(2'd2, 8'hFF); w = cyc;
        expect_at(w, 0, lvl(1, 1), "R7 clear edge");
        tick(1);
        expect_at(cyc, 0, lvl(1, 0), "R7 early release");
        tick(1);

        // R8: both bits set acts as level
        reg_wr(2'd0, 8'h07);
        reg_wr(2'd1, 8'd1);
        pulse_evt(1);
        tick(20);
        expect_at(cyc, 0, lvl(1, 1), "R8 no timeout");
        reg_wr(2'd2, 8'hFF);
        tick(1);
        expect_at(cyc, 0, lvl(1, 0), "R8 release");

        // R10: external input is edge sensitive
        reg_wr(2'd0, 8'h04);
        ext_irq = 1'b1;
        tick(1); e = cyc;
        expect_at(e,       0, lvl(1, 1), "R10 assert");
        expect_at(e + D-1, 0, lvl(1, 1), "R10 pulse");
        expect_at(e + D,   0, lvl(1, 0), "R10 end");
        expect_at(e + D,   1, 8'h10,     "R10 R12 status bit 4");
        tick_to(e + D + 2);
        expect_at(cyc, 0, lvl(1, 0), "R10 no retrigger");
        reg_wr(2'd2, 8'hFF);
        tick(1);
        expect_at(cyc, 1, 8'h00, "R10 no reset after clear");
        expect_at(cyc, 0, lvl(1, 0), "R10 line idle");
        ext_irq = 1'b0;
        tick(1);

        // R9: set beats clear in the same cycle
        evt_req[0] = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h01;
        tick(1);
        evt_req = '0; wr_en = 1'b0;
        expect_at(cyc, 1, 8'h01, "R9 set wins");
        tick(D + 2);
        reg_wr(2'd2, 8'hFF);

        // R11: interval zero is one tick
        reg_wr(2'd1, 8'd0);
        pulse_evt(2); e = cyc;
        expect_at(e + D-1, 0, lvl(1, 1), "R11 one tick");
        expect_at(e + D,   0, lvl(1, 0), "R11 end");
        tick_to(e + D);

        // R12: control readback and unused address
        rd_addr = 2'd0; expect_at(cyc, 1, 8'h04, "R12 ctrl");
        tick(1); rd_addr = 2'd3; expect_at(cyc, 1, 8'h00, "R12 addr 3");
        tick(1); rd_addr = 2'd2;

        while (sb.size() > 0) tick(1);
        tick(1);
        finish_run();
    end

endmodule